// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block selects among a fixed number of interrupt inputs and drives a single interrupt request line toward a processor. Each input has a configuration word that holds an 8-bit vector, a 4-bit priority, a mask bit and a trigger-mode bit (level or rising edge). A task priority register sets a floor: an input must be strictly above the floor to request.

Software takes an interrupt by reading the acknowledge address. The read returns the vector of the source that wins at that moment and marks that source as in service. It ends the handler by writing the end-of-interrupt address, which retires the highest-priority in-service source. Interrupts nest. While some sources are in service, only a source whose priority is strictly above all of them can raise the request again. If no source qualifies when the acknowledge read arrives, the read returns a programmable spurious vector and changes no state.

The register port is a plain single-cycle strobe interface with no back-pressure. A read strobe in one cycle produces `rd_valid` and `rd_data` in the next cycle. Software must not issue reads and writes faster than one per cycle. The request line `irq` is combinational from the registered state and the level inputs.

Top module: `pic_nest_top`

## Requirements
- R1: A read of address 0 while `irq` is high returns, one cycle later with `rd_valid` high, the winning source's vector in `rd_data[7:0]` with zeros above it. The read also places that source in service.
- R2: `irq` is high exactly when some eligible source has a priority strictly greater than the task priority and strictly greater than every in-service source's priority. An eligible source is one that is pending, unmasked and has nonzero priority.
- R3: The winner is the eligible source with the highest priority. When priorities tie, the lowest source index wins.
- R4: A write to address 1 removes only the highest-priority in-service source. Repeated writes therefore retire nested sources in descending priority order.
- R5: A read of address 0 while no source qualifies returns the spurious vector. This covers a level input that dropped, a source that was masked, a task priority that was raised, and a read with nothing pending.
- R6: A spurious acknowledge changes neither the in-service set nor any latched edge pending state.
- R7: A write to address 1 while nothing is in service has no effect.
- R8: In edge mode (config bit 14 = 1), a rising input edge latches a pending flag. Only an acknowledge that selects that source clears the flag. In level mode (bit 14 = 0), pending equals the input.
- R9: A source with priority 0 never requests and never wins.
- R10: The address map is: 2 holds the task priority in bits [3:0]; 3 holds the spurious vector in bits [7:0]; 4+i holds source i's 16-bit configuration (vector [7:0], priority [11:8], edge mode [14], mask [15]). All of these read back as written. Reset values are task 0, spurious 0xFF, and every source configuration 0x8000 (masked).
- R11: `irq` falls in the cycle that follows an acknowledge which removed the last qualifying source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Interrupt inputs, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rd_data | output | 16 | Read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC = 4 and ADDR_W = 4. With that size, every combination of per-source priorities 0..3, crossed with every task priority 0..3, can be swept with all inputs asserted. That sweep covers ties, priority-zero sources, the floor comparison, and the acknowledge/end-of-interrupt round trip. Directed sequences then use distinct priorities to build a three-deep nest, retire it one level at a time, and provoke each spurious case, including one with an edge-latched source that must survive the spurious read.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned PRIO_W       = 4;
  localparam int unsigned VEC_W        = 8;
  localparam int unsigned ADDR_ACK     = 0;
  localparam int unsigned ADDR_EOI     = 1;
  localparam int unsigned ADDR_TASK    = 2;
  localparam int unsigned ADDR_SPUR    = 3;
  localparam int unsigned ADDR_SRC0    = 4;
  localparam int unsigned CFG_PRIO_LSB = 8;
  localparam int unsigned CFG_EDGE_BIT = 14;
  localparam int unsigned CFG_MASK_BIT = 15;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio_flat,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   top_prio
);
  // Strict '>' keeps the lowest index on ties.
  always_comb begin
    found    = 1'b0;
    idx      = '0;
    top_prio = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req[i] && (!found || prio_flat[i*PW +: PW] > top_prio)) begin
        found    = 1'b1;
        idx      = IW'(i);
        top_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/pic_source.sv
module pic_source (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic edge_mode,
  input  logic ack_clr,
  output logic pending
);
  logic src_q;
  logic latch_q;
  logic rise;

  assign rise = src_in && !src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      src_q <= src_in;
      if (!edge_mode)   latch_q <= 1'b0;
      else if (rise)    latch_q <= 1'b1;
      else if (ack_clr) latch_q <= 1'b0;
    end
  end

  assign pending = edge_mode ? latch_q : src_in;

  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && latch_q && !ack_clr |=> latch_q || !edge_mode)
    else $error("latched edge lost without acknowledge");

  assert_edge_catch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && src_in && !src_q |=> pending || !edge_mode)
    else $error("rising edge not latched");
endmodule

// File: rtl/pic_insvc.sv
module pic_insvc #(
  parameter int unsigned N  = 4,
  parameter int unsigned PW = 4,
  parameter int unsigned IW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IW-1:0]   set_idx,
  input  logic            eoi,
  input  logic [N*PW-1:0] prio_flat,
  output logic [N-1:0]    active,
  output logic            top_valid,
  output logic [PW-1:0]   top_prio
);
  logic [IW-1:0] top_idx;

  pic_prio_pick #(.N(N), .PW(PW), .IW(IW)) u_top (
    .req(active), .prio_flat(prio_flat),
    .found(top_valid), .idx(top_idx), .top_prio(top_prio)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else begin
      if (eoi && top_valid) active[top_idx] <= 1'b0;
      if (set_en)           active[set_idx] <= 1'b1;
    end
  end

  assert_ack_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> active[$past(set_idx)])
    else $error("acknowledged source not in service");

  assert_eoi_retires_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && top_valid && !set_en |=> $countones(active) == $countones($past(active)) - 1)
    else $error("end of interrupt did not retire exactly one source");

  assert_eoi_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && active == '0 && !set_en |=> active == '0)
    else $error("stray end of interrupt changed state");
endmodule

// File: rtl/pic_nest_top.sv
module pic_nest_top #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [15:0]         reg_wdata,
  output logic                rd_valid,
  output logic [15:0]         rd_data,
  output logic                irq
);
  import pic_pkg::*;
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC*DATA_W-1:0] cfg_flat;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        eligible;
  logic [NUM_SRC-1:0]        ins_active;
  logic [PRIO_W-1:0]         task_q;
  logic [VEC_W-1:0]          spur_q;
  logic                      win_found, ins_valid, qualify, ack_hit, take, eoi_hit;
  logic [IW-1:0]             win_idx;
  logic [PRIO_W-1:0]         win_prio, ins_top;
  logic [15:0]               rd_next;

  assign ack_hit = reg_rd && reg_addr == ADDR_W'(ADDR_ACK);
  assign eoi_hit = reg_wr && reg_addr == ADDR_W'(ADDR_EOI);
  assign take    = ack_hit && qualify;

  for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_src
    logic [DATA_W-1:0] cfg_r;
    logic              pend;
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_r <= DATA_W'(1) << CFG_MASK_BIT;
      else if (reg_wr && reg_addr == ADDR_W'(ADDR_SRC0 + i)) cfg_r <= reg_wdata;
    end
    pic_source u_src (
      .clk(clk), .rst_n(rst_n), .src_in(src_in[i]),
      .edge_mode(cfg_r[CFG_EDGE_BIT]),
      .ack_clr(take && win_idx == IW'(i)),
      .pending(pend)
    );
    assign cfg_flat[i*DATA_W +: DATA_W] = cfg_r;
    assign prio_flat[i*PRIO_W +: PRIO_W] = cfg_r[CFG_PRIO_LSB +: PRIO_W];
    assign eligible[i] = pend && !cfg_r[CFG_MASK_BIT] &&
                         cfg_r[CFG_PRIO_LSB +: PRIO_W] != '0;
  end

  pic_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IW)) u_win (
    .req(eligible), .prio_flat(prio_flat),
    .found(win_found), .idx(win_idx), .top_prio(win_prio)
  );

  pic_insvc #(.N(NUM_SRC), .PW(PRIO_W), .IW(IW)) u_insvc (
    .clk(clk), .rst_n(rst_n), .set_en(take), .set_idx(win_idx),
    .eoi(eoi_hit), .prio_flat(prio_flat),
    .active(ins_active), .top_valid(ins_valid), .top_prio(ins_top)
  );

  assign qualify = win_found && win_prio > task_q && (!ins_valid || win_prio > ins_top);
  assign irq     = qualify;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      task_q <= '0;
      spur_q <= '1;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(ADDR_TASK)) task_q <= reg_wdata[PRIO_W-1:0];
      if (reg_addr == ADDR_W'(ADDR_SPUR)) spur_q <= reg_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(ADDR_ACK)) begin
      rd_next = {8'h00, spur_q};
      if (qualify)
        for (int i = 0; i < int'(NUM_SRC); i++)
          if (win_idx == IW'(i)) rd_next = {8'h00, cfg_flat[i*DATA_W +: VEC_W]};
    end else if (reg_addr == ADDR_W'(ADDR_TASK)) begin
      rd_next = {12'h000, task_q};
    end else if (reg_addr == ADDR_W'(ADDR_SPUR)) begin
      rd_next = {8'h00, spur_q};
    end else begin
      for (int i = 0; i < int'(NUM_SRC); i++)
        if (reg_addr == ADDR_W'(ADDR_SRC0 + i)) rd_next = cfg_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_next;
    end
  end

  assert_spurious_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit && !qualify |=> rd_valid && rd_data == {8'h00, $past(spur_q)})
    else $error("spurious acknowledge returned wrong data");

  assert_spurious_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit && !qualify |=> ins_active == $past(ins_active))
    else $error("spurious acknowledge altered in-service set");

  assert_take_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $countones(ins_active) == $countones($past(ins_active)) + 1)
    else $error("acknowledge did not add an in-service source");
endmodule

// File: tb/pic_nest_top_tb.sv
module pic_nest_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        rd_valid, irq;
  logic [15:0] rd_data;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  pic_nest_top #(.NUM_SRC(4), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    chk("R1 rd_valid", {15'b0, rd_valid}, 16'h0001);
    d = rd_data;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src_in[i] = 1'b1;
    @(negedge clk); src_in[i] = 1'b0;
  endtask

  logic [15:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq after reset", {15'b0, irq}, 16'h0000);
    rd(4'd3, d); chk("R10 spurious reset", d, 16'h00FF);
    rd(4'd2, d); chk("R10 task reset", d, 16'h0000);
    rd(4'd4, d); chk("R10 source cfg reset", d, 16'h8000);
    rd(4'd0, d); chk("R5 ack with nothing pending", d, 16'h00FF);

    // Sweep: priorities 0..3 per source, task 0..3, all level inputs high
    src_in = 4'hF;
    for (int combo = 0; combo < 256; combo++) begin
      for (int t = 0; t < 4; t++) begin
        int p [4];
        int best, bp;
        logic q;
        best = -1; bp = 0;
        for (int i = 0; i < 4; i++) begin
          p[i] = (combo >> (2*i)) & 3;
          if (p[i] != 0 && (best < 0 || p[i] > bp)) begin best = i; bp = p[i]; end
        end
        q = (best >= 0) && (bp > t);
        for (int i = 0; i < 4; i++) wr(4'(4+i), {4'h0, 4'(p[i]), 8'(8'h10 + i)});
        wr(4'd2, 16'(t));
        chk("R2 R3 R9 irq sweep", {15'b0, irq}, {15'b0, q});
        rd(4'd0, d);
        chk("R1 R3 R5 ack vector sweep", d, q ? 16'(8'h10 + best) : 16'h00FF);
        if (q) begin
          chk("R11 irq drops after ack", {15'b0, irq}, 16'h0000);
          wr(4'd1, 16'h0);
          chk("R4 irq returns after eoi", {15'b0, irq}, 16'h0001);
        end
      end
    end
    src_in = '0;
    wr(4'd2, 16'h0);

    // Directed nesting: s0 p2, s1 p5, s2 p9, s3 p7 edge mode
    wr(4'd4, 16'h02A0); wr(4'd5, 16'h05A1); wr(4'd6, 16'h09A2); wr(4'd7, 16'h47A3);
    rd(4'd7, d); chk("R10 cfg readback", d, 16'h47A3);
    src_in[0] = 1'b1; @(negedge clk);
    chk("R2 irq first level", {15'b0, irq}, 16'h0001);
    rd(4'd0, d); chk("R1 ack s0", d, 16'h00A0); src_in[0] = 1'b0;
    src_in[1] = 1'b1; @(negedge clk);
    chk("R2 nested preempt", {15'b0, irq}, 16'h0001);
    rd(4'd0, d); chk("R1 ack s1", d, 16'h00A1); src_in[1] = 1'b0;
    src_in[2] = 1'b1; @(negedge clk);
    rd(4'd0, d); chk("R1 ack s2", d, 16'h00A2); src_in[2] = 1'b0;
    src_in[0] = 1'b1; @(negedge clk);
    chk("R2 lower blocked by in-service", {15'b0, irq}, 16'h0000);
    rd(4'd0, d); chk("R5 ack below in-service", d, 16'h00FF);
    src_in[0] = 1'b0;
    wr(4'd1, 16'h0);            // retires s2, top now 5
    pulse(3);
    chk("R4 R8 edge source after retire", {15'b0, irq}, 16'h0001);
    rd(4'd0, d); chk("R8 ack edge source", d, 16'h00A3);
    chk("R11 irq low after ack", {15'b0, irq}, 16'h0000);
    wr(4'd1, 16'h0);            // retires s3
    chk("R8 edge pending cleared by ack", {15'b0, irq}, 16'h0000);
    wr(4'd1, 16'h0);            // retires s1, top now 2
    src_in[1] = 1'b1; @(negedge clk);
    chk("R4 descending retire order", {15'b0, irq}, 16'h0001);
    src_in[1] = 1'b0;
    wr(4'd1, 16'h0);            // retires s0
    wr(4'd1, 16'h0);            // nothing in service
    src_in[0] = 1'b1; @(negedge clk);
    chk("R7 stray eoi ignored", {15'b0, irq}, 16'h0001);
    rd(4'd0, d); chk("R7 ack after stray eoi", d, 16'h00A0);
    src_in[0] = 1'b0;
    wr(4'd1, 16'h0);
    chk("R7 idle after final eoi", {15'b0, irq}, 16'h0000);

    // Spurious cases
    wr(4'd3, 16'h005A);
    src_in[1] = 1'b1; @(negedge clk);
    chk("R2 irq before mask", {15'b0, irq}, 16'h0001);
    wr(4'd5, 16'h85A1);
    chk("R5 mask drops irq", {15'b0, irq}, 16'h0000);
    rd(4'd0, d); chk("R5 masked then ack", d, 16'h005A);
    wr(4'd5, 16'h05A1);
    chk("R6 level pending intact", {15'b0, irq}, 16'h0001);
    wr(4'd2, 16'h0006);
    chk("R2 task floor blocks", {15'b0, irq}, 16'h0000);
    rd(4'd0, d); chk("R5 task raised then ack", d, 16'h005A);
    wr(4'd2, 16'h0005);
    chk("R2 task equal blocks", {15'b0, irq}, 16'h0000);
    wr(4'd2, 16'h0000);
    chk("R6 in-service untouched by spurious", {15'b0, irq}, 16'h0001);
    src_in[1] = 1'b0; @(negedge clk);
    rd(4'd0, d); chk("R5 level dropped then ack", d, 16'h005A);
    wr(4'd2, 16'h0008);
    pulse(3);
    chk("R2 edge below floor", {15'b0, irq}, 16'h0000);
    rd(4'd0, d); chk("R5 edge below floor ack", d, 16'h005A);
    wr(4'd2, 16'h0000);
    chk("R6 edge pending survives spurious", {15'b0, irq}, 16'h0001);
    rd(4'd0, d); chk("R8 edge ack after spurious", d, 16'h00A3);
    chk("R11 irq low after last ack", {15'b0, irq}, 16'h0000);
    wr(4'd1, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule